// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the front end of a host bridge. It sits between a CPU-side register bus and a PCI configuration access port. Software first writes a 32-bit configuration address into a holding register through an address window. That value uses a slot-select layout: one bit among the upper bits picks the target device, like an IDSEL line. Each later access through the data window is converted into a standard configuration address, with the bus number set to zero. In that address the device number is encoded, the function and register fields are kept, and the low three bits come from the data-window offset.

Two compatibility paths bypass the slot decode. If bit 31 of the holding register is set, or if bit 0 is set, the stored value is passed through almost unchanged. Data passes through a byte-lane swap sized by the access length, so that a big-endian host sees PCI little-endian data in its natural order. A slot-select value with no slot bit set targets no device: reads return all-ones and writes are dropped. Each forwarded request is held on the downstream port until that port acknowledges it. The host access is stalled for the whole of that time.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the holding register reads back as 0x00000000 through the address window (`host_addr[12]`=0).
- R2: A write through the address window stores all 32 bits of `host_wdata`, whatever the length. A read through the address window returns the stored value. Both complete with `host_ready` high in the same cycle as `host_req`.
- R3: When holding-register bit 31 is 1, a data-window access (`host_addr[12]`=1) is forwarded with `cfg_addr` = {reg[31:2], host_addr[1:0]}.
- R4: When bit 31 is 0 and bit 0 is 1, `cfg_addr` = {reg[31:3], host_addr[2:0]}.
- R5: When bits 31 and 0 are both 0 and some bit of reg[30:11] is set, `cfg_addr` is built as follows:
  - bits [31:16] are zero;
  - bits [15:11] hold the bit index (11..30) of the lowest set bit in reg[31:11];
  - bits [10:8] hold reg[10:8];
  - bits [7:3] hold reg[7:3];
  - bits [2:0] hold host_addr[2:0].
- R6: When bits 31 and 0 are 0 and reg[31:11] is zero, no downstream request is made. A read returns all-ones in the accessed lanes: 0xFF for length 1, 0xFFFF for length 2, 0xFFFFFFFF for length 4. A write is dropped.
- R7: Forwarded write data is lane-swapped by length and zero-extended. `cfg_len` carries the host length.
  - Length 1 (`host_len`=1) gives d[7:0].
  - Length 2 gives {d[7:0], d[15:8]}.
  - Length 4, and any other code, reverses all four bytes.
- R8: Read data returned on `cfg_rdata` is given to the host with the same lane swap as R7, using the access length.
- R9: `cfg_valid`, `cfg_addr`, `cfg_len`, `cfg_we` and `cfg_wdata` stay constant until `cfg_ready` is sampled high. `host_ready` stays low while `cfg_valid` is high. The host access completes in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_addr | input | 13 | Bit 12 selects the window (0 address, 1 data); low bits are the offset |
| host_we | input | 1 | 1 = write, 0 = read |
| host_len | input | 3 | Access length in bytes (1, 2 or 4) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access completes this cycle |
| host_rdata | output | 32 | Read data, valid with host_ready |
| cfg_valid | output | 1 | Downstream configuration request valid |
| cfg_ready | input | 1 | Downstream acknowledge |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_len | output | 3 | Access length in bytes |
| cfg_we | output | 1 | Downstream write |
| cfg_wdata | output | 32 | Lane-swapped write data |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ready |

## Verification
The bench sweeps every slot bit from 11 to 30, together with every function number and every data-window offset. Stray slot bits are set above the wanted one, so a decoder that picked the highest set bit, or that encoded the position minus 11, would forward the wrong device field. The bypass paths are run with offsets whose bit 2 differs, which shows a mix-up between the 2-bit and the 3-bit replacement. An empty slot field is probed at each length: a design that forwarded the request, or returned unmasked ones, shows up at once. Lane order is checked at all three lengths on both reads and writes. The acknowledge is delayed by up to three cycles, which catches a request that changes early or a host that is released too soon.

// File: rtl/cax_pkg.sv
`timescale 1ns/1ps
package cax_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } cax_state_e;

    typedef struct packed {
        cax_state_e  state;
        logic [31:0] hold;
        logic [31:0] addr;
        logic [2:0]  len;
        logic        we;
        logic [31:0] wdata;
        logic [31:0] rdata;
    } cax_regs_t;
endpackage

// File: rtl/cax_lane_swap.sv
`timescale 1ns/1ps
module cax_lane_swap #(
    parameter int BYTES = 4
) (
    input  logic [2:0]         len_i,
    input  logic [8*BYTES-1:0] d_i,
    output logic [8*BYTES-1:0] d_o
);
    localparam int W = 8 * BYTES;

    logic [W-1:0] rev;

    for (genvar g = 0; g < BYTES; g++) begin : g_rev
        assign rev[8*g +: 8] = d_i[8*(BYTES-1-g) +: 8];
    end

    always_comb begin
        d_o = '0;
        case (len_i)
            3'd1:    d_o[7:0]  = d_i[7:0];
            3'd2:    d_o[15:0] = {d_i[7:0], d_i[15:8]};
            default: d_o       = rev;
        endcase
    end
endmodule

// File: rtl/cax_addr_map.sv
`timescale 1ns/1ps
module cax_addr_map #(
    parameter int AW      = 32,
    parameter int SLOT_LO = 11,
    parameter int FN_LO   = 8,
    parameter int OFF_W   = 3
) (
    input  logic [AW-1:0]    reg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [AW-1:0]    addr_o,
    output logic             nodev_o
);
    localparam int SLOT_W = $clog2(AW);

    logic              found;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = AW - 1; i >= SLOT_LO; i--) begin
            if (reg_i[i]) begin
                found = 1'b1;
                slot  = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        nodev_o = 1'b0;
        addr_o  = '0;
        if (reg_i[AW-1]) begin
            addr_o = {reg_i[AW-1:2], off_i[1:0]};
        end else if (reg_i[0]) begin
            addr_o = {reg_i[AW-1:OFF_W], off_i};
        end else begin
            addr_o[OFF_W-1:0]             = off_i;
            addr_o[FN_LO-1:OFF_W]         = reg_i[FN_LO-1:OFF_W];
            addr_o[SLOT_LO-1:FN_LO]       = reg_i[SLOT_LO-1:FN_LO];
            addr_o[SLOT_LO+SLOT_W-1:SLOT_LO] = slot;
            nodev_o                       = !found;
        end
    end
endmodule

// File: rtl/cfg_addr_xlate.sv
`timescale 1ns/1ps
module cfg_addr_xlate
    import cax_pkg::*;
#(
    parameter int WIN_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic [WIN_W:0] host_addr,
    input  logic          host_we,
    input  logic [2:0]    host_len,
    input  logic [31:0]   host_wdata,
    output logic          host_ready,
    output logic [31:0]   host_rdata,
    output logic          cfg_valid,
    input  logic          cfg_ready,
    output logic [31:0]   cfg_addr,
    output logic [2:0]    cfg_len,
    output logic          cfg_we,
    output logic [31:0]   cfg_wdata,
    input  logic [31:0]   cfg_rdata
);
    localparam int OFF_W   = 3;
    localparam int SEL_BIT = WIN_W;

    cax_regs_t st_d, st_q;

    logic [31:0] map_addr;
    logic        map_nodev;
    logic [31:0] wsw_out;
    logic [31:0] rsw_in;
    logic [2:0]  rsw_len;
    logic [31:0] rsw_out;
    logic        unused_bits;

    assign unused_bits = ^host_addr[WIN_W-1:OFF_W];

    cax_addr_map #(.AW(32), .SLOT_LO(11), .FN_LO(8), .OFF_W(OFF_W)) u_map (
        .reg_i   (st_q.hold),
        .off_i   (host_addr[OFF_W-1:0]),
        .addr_o  (map_addr),
        .nodev_o (map_nodev)
    );

    cax_lane_swap #(.BYTES(4)) u_wswap (
        .len_i (host_len),
        .d_i   (host_wdata),
        .d_o   (wsw_out)
    );

    assign rsw_in  = (st_q.state == ST_WAIT) ? cfg_rdata : '1;
    assign rsw_len = (st_q.state == ST_WAIT) ? st_q.len  : host_len;

    cax_lane_swap #(.BYTES(4)) u_rswap (
        .len_i (rsw_len),
        .d_i   (rsw_in),
        .d_o   (rsw_out)
    );

    always_comb begin
        st_d       = st_q;
        host_ready = 1'b0;
        host_rdata = '0;
        case (st_q.state)
            ST_IDLE: begin
                if (host_req) begin
                    if (!host_addr[SEL_BIT]) begin
                        host_ready = 1'b1;
                        if (host_we) st_d.hold = host_wdata;
                        else         host_rdata = st_q.hold;
                    end else if (map_nodev) begin
                        host_ready = 1'b1;
                        if (!host_we) host_rdata = rsw_out;
                    end else begin
                        st_d.state = ST_WAIT;
                        st_d.addr  = map_addr;
                        st_d.len   = host_len;
                        st_d.we    = host_we;
                        st_d.wdata = host_we ? wsw_out : '0;
                    end
                end
            end
            ST_WAIT: begin
                if (cfg_ready) begin
                    st_d.state = ST_DONE;
                    st_d.rdata = st_q.we ? '0 : rsw_out;
                end
            end
            ST_DONE: begin
                host_ready = 1'b1;
                host_rdata = st_q.rdata;
                st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, hold: '0, addr: '0, len: '0,
                      we: 1'b0, wdata: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_valid = (st_q.state == ST_WAIT);
    assign cfg_addr  = st_q.addr;
    assign cfg_len   = st_q.len;
    assign cfg_we    = st_q.we;
    assign cfg_wdata = st_q.wdata;

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) &&
        $stable(cfg_wdata) && $stable(cfg_len) && $stable(cfg_we));

    // R9
    stall_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !host_ready);

    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready |=> host_ready && !cfg_valid);

    // R6
    nodev_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == ST_IDLE && host_req && host_addr[SEL_BIT] && map_nodev
        |=> !cfg_valid);

    // R2
    addr_win_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == ST_IDLE && host_req && !host_addr[SEL_BIT] |-> host_ready);

    // R7
    narrow_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_we && cfg_len == 3'd2 |-> cfg_wdata[31:16] == 16'h0);
endmodule

// File: tb/sim_cfg_addr_xlate.sv
`timescale 1ns/1ps
module sim_cfg_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [12:0] host_addr = '0;
    logic        host_we = 1'b0;
    logic [2:0]  host_len = 3'd4;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        cfg_valid;
    logic        cfg_ready = 1'b0;
    logic [31:0] cfg_addr;
    logic [2:0]  cfg_len;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    cfg_addr_xlate u0 (.*);

    function automatic logic [31:0] swp(input logic [31:0] d, input logic [2:0] len);
        if (len == 3'd1) return d & 32'hFF;
        if (len == 3'd2) return ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF);
        return ((d & 32'hFF) << 24) | (((d >> 8) & 32'hFF) << 16) |
               (((d >> 16) & 32'hFF) << 8) | ((d >> 24) & 32'hFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    logic        f_seen;
    logic [31:0] f_addr, f_wdata, f_rd;
    logic [2:0]  f_len;
    logic        f_we;
    logic        f_bad;

    task automatic acc(input logic win, input logic [2:0] off, input logic we,
                       input logic [2:0] len, input logic [31:0] wd,
                       input int dly, input logic [31:0] ret);
        int waited = 0;
        @(negedge clk);
        host_req = 1'b1; host_addr = {win, 9'h0A5, off}; host_we = we;
        host_len = len;  host_wdata = wd;
        f_seen = 1'b0; f_bad = 1'b0; f_rd = '0;
        for (int n = 0; n < 40; n++) begin
            #1;
            if (host_ready && cfg_valid) f_bad = 1'b1;
            if (host_ready) begin
                f_rd = host_rdata;
                break;
            end
            if (cfg_valid) begin
                if (!f_seen) begin
                    f_addr = cfg_addr; f_wdata = cfg_wdata; f_len = cfg_len; f_we = cfg_we;
                end else if (cfg_addr !== f_addr || cfg_wdata !== f_wdata ||
                             cfg_len !== f_len || cfg_we !== f_we) begin
                    f_bad = 1'b1;
                end
                f_seen = 1'b1;
                if (waited == dly) begin
                    cfg_ready = 1'b1; cfg_rdata = ret;
                end
                waited++;
            end
            @(negedge clk);
            cfg_ready = 1'b0;
        end
        @(negedge clk);
        host_req = 1'b0;
        cfg_ready = 1'b0;
    endtask

    task automatic set_hold(input logic [31:0] v);
        acc(1'b0, 3'd0, 1'b1, 3'd4, v, 0, 0);
    endtask

    initial begin
        logic [31:0] r, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value
        acc(1'b0, 3'd0, 1'b0, 3'd4, 0, 0, 0);
        chk("R1 hold after reset", f_rd, 32'h0);

        // R2 store and read back, length ignored
        acc(1'b0, 3'd2, 1'b1, 3'd1, 32'hDEADBEEF, 0, 0);
        acc(1'b0, 3'd0, 1'b0, 3'd2, 0, 0, 0);
        chk("R2 readback", f_rd, 32'hDEADBEEF);
        chk("R2 no forward", {31'h0, f_seen}, 32'h0);

        // R5 slot decode sweep, R8 read swap
        for (int b = 11; b <= 30; b++) begin
            for (int f = 0; f < 8; f++) begin
                r = (32'h1 << b) | (32'(f) << 8) | ((32'(b * 8 + f) << 3) & 32'hF8);
                if (b < 29) r = r | (32'h1 << (b + 2));
                set_hold(r);
                for (int o = 0; o < 8; o++) begin
                    logic [2:0] ln;
                    ln = (o % 3 == 0) ? 3'd1 : ((o % 3 == 1) ? 3'd2 : 3'd4);
                    e = (32'(b) << 11) | (32'(f) << 8) | (r & 32'hF8) | 32'(o);
                    acc(1'b1, 3'(o), 1'b0, ln, 0, (b + f + o) % 4, e ^ 32'hA1B2C3D4);
                    chk("R5 slot addr", f_addr, e);
                    chk("R8 read swap", f_rd, swp(e ^ 32'hA1B2C3D4, ln));
                    chk("R9 hold/stall", {31'h0, f_bad}, 32'h0);
                end
            end
        end

        // R3 bit31 pass-through
        for (int o = 0; o < 8; o++) begin
            r = 32'h8123_4560 | 32'(o * 5);
            set_hold(r);
            acc(1'b1, 3'(o), 1'b0, 3'd4, 0, 1, 32'h0);
            chk("R3 bypass addr", f_addr, (r & 32'hFFFFFFFC) | 32'(o & 3));
        end

        // R4 bit0 pass-through
        for (int o = 0; o < 8; o++) begin
            r = 32'h0045_6701 | 32'(o << 3);
            set_hold(r);
            acc(1'b1, 3'(o), 1'b1, 3'd4, 32'h11223344, 2, 32'h0);
            chk("R4 bypass addr", f_addr, (r & 32'hFFFFFFF8) | 32'(o));
            chk("R7 write swap len4", f_wdata, 32'h44332211);
        end

        // R6 no device
        set_hold(32'h0000_07F8);
        acc(1'b1, 3'd1, 1'b0, 3'd1, 0, 0, 0);
        chk("R6 nodev len1", f_rd, 32'hFF);
        chk("R6 nodev no forward", {31'h0, f_seen}, 32'h0);
        acc(1'b1, 3'd2, 1'b0, 3'd2, 0, 0, 0);
        chk("R6 nodev len2", f_rd, 32'hFFFF);
        acc(1'b1, 3'd0, 1'b0, 3'd4, 0, 0, 0);
        chk("R6 nodev len4", f_rd, 32'hFFFFFFFF);
        acc(1'b1, 3'd0, 1'b1, 3'd4, 32'h12345678, 0, 0);
        chk("R6 write dropped", {31'h0, f_seen}, 32'h0);

        // R7 write swap by length
        set_hold(32'h0000_2210);
        for (int k = 0; k < 3; k++) begin
            logic [2:0] ln;
            ln = (k == 0) ? 3'd1 : ((k == 1) ? 3'd2 : 3'd4);
            acc(1'b1, 3'd4, 1'b1, ln, 32'hCAFE_B00C, k, 0);
            chk("R7 write data", f_wdata, swp(32'hCAFE_B00C, ln));
            chk("R7 len forwarded", {29'h0, f_len}, {29'h0, ln});
            chk("R7 we forwarded", {31'h0, f_we}, 32'h1);
            chk("R5 slot13 addr", f_addr, (32'd13 << 11) | (32'd2 << 8) | 32'h14);
        end

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule